// File: doc/BRIEF.md
# DMA Controller Control-Port Register Block

This block is the control side of a four-channel DMA controller. A byte-wide register port carries eight control operations, chosen by the low offset bits of the address. The operations load the command register, raise or drop a software request, mask or unmask one channel, load a channel's mode byte, reset the byte-pointer flip-flop, perform a master reset, unmask every channel, or load the whole mask at once. Two offsets can be read. One returns the status byte and clears its terminal-count half as a side effect. The other returns the mask.

The block holds the command, mask, status and per-channel mode state, along with the byte-pointer flip-flop used by the channel address and count registers. Each channel's mode is exported as decoded fields. A one-cycle rescan pulse tells the channel service scanner that a mask or a request has changed. A separate per-channel interface lets peripherals hold or release a request, and lets the transfer engine flag terminal count. An address shift parameter selects byte-spaced decoding (0) or word-spaced decoding (1).

Top module: `dmac_ctrl_regs`

## Requirements
- R1: A synchronous reset sets all four mask bits and clears status, command, byte pointer, all mode fields and rdata.
- R2: A write to offset 0 loads the command register only if no bit outside bit 2 is set (mask 8'hFB is zero). Any other value leaves the command unchanged.
- R3: A write to offset 1 selects a channel with data[1:0]. Data bit 2 sets or clears that channel's request bit (status bit 4+ch). The write always clears that channel's terminal-count bit (status bit ch).
- R4: A write to offset 2 selects a channel with data[1:0]. Data bit 2 sets (1) or clears (0) that channel's mask bit.
- R5: A write to offset 3 updates only the channel chosen by data[1:0], loading these fields: data[3:2] as transfer type, data[4] as auto-initialize, data[5] as address decrement and data[7:6] as operating mode.
- R6: The byte pointer toggles on each ptr_toggle cycle and is cleared by a write to offset 4.
- R7: A write to offset 5 clears the byte pointer, sets all mask bits, and clears status and command.
- R8: A write to offset 6 clears all mask bits. A write to offset 7 loads the mask from data[3:0].
- R9: A read of offset 0 returns the status byte on rdata in the next cycle, with request bits in [7:4] and terminal-count bits in [3:0]. The same read clears status[3:0] and keeps status[7:4].
- R10: A read of offset 1 returns {4'b0, mask} on rdata in the next cycle. A read of any other offset returns 0.
- R11: rescan is high for exactly the one cycle after a write to offset 1, 2, 6 or 7, or after any ext_hold or ext_release bit is set. It stays low otherwise.
- R12: The offset is addr[ADDR_SHIFT+3:ADDR_SHIFT]. Writes to offsets 8 to 15 change nothing.
- R13: ext_hold[ch] sets and ext_release[ch] clears request bit ch. Both take precedence over any port write in the same cycle, and hold wins when both are set.
- R14: tc_set[ch] sets terminal-count bit ch, taking precedence over any clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Port write strobe |
| rd_en | input | 1 | Port read strobe |
| addr | input | ADDR_W | Port address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| ext_hold | input | 4 | Per-channel request assert |
| ext_release | input | 4 | Per-channel request release |
| tc_set | input | 4 | Per-channel terminal-count flag |
| ptr_toggle | input | 1 | Byte-pointer toggle from the channel registers |
| byte_ptr | output | 1 | Byte-pointer flip-flop |
| cmd_q | output | 8 | Command register |
| mask_q | output | 4 | Channel mask bits |
| status_q | output | 8 | Status: requests [7:4], terminal counts [3:0] |
| rescan | output | 1 | Channel rescan pulse |
| mode_xfer | output | 8 | Transfer type, 2 bits per channel |
| mode_autoinit | output | 4 | Auto-initialize per channel |
| mode_decr | output | 4 | Address decrement per channel |
| mode_op | output | 8 | Operating mode, 2 bits per channel |

## Verification
Every piece of state drives an output directly: command, mask, status, byte pointer and each mode field. A wrong decode or update is therefore visible one cycle after the write that caused it. A missed or extra rescan would show as a pulse in the wrong cycle, or no pulse at all, and the scanner would stall or churn. A faulty destructive read would show only on the read after next, when terminal-count bits reappear or request bits vanish. For that reason the bench reads status twice in a row.

// File: rtl/dmac_ctrl_pkg.sv
package dmac_ctrl_pkg;
    localparam int NUM_CH   = 4;
    localparam int CH_SEL_W = $clog2(NUM_CH);
    localparam logic [7:0] CMD_UNSUP = 8'hFB;

    typedef enum logic [2:0] {
        OP_CMD     = 3'd0,
        OP_REQ     = 3'd1,
        OP_SMASK   = 3'd2,
        OP_MODE    = 3'd3,
        OP_CLRPTR  = 3'd4,
        OP_MRESET  = 3'd5,
        OP_CLRMASK = 3'd6,
        OP_WRMASK  = 3'd7
    } ctl_op_e;

    typedef struct packed {
        logic       valid;
        ctl_op_e    op;
    } ctl_wr_t;

    typedef struct packed {
        logic [1:0] op_mode;
        logic       decr;
        logic       autoinit;
        logic [1:0] xfer;
    } chan_mode_t;

    function automatic logic cmd_allowed(input logic [7:0] d);
        return (d & CMD_UNSUP) == 8'h00;
    endfunction
endpackage

// File: rtl/dmac_ctrl_decode.sv
module dmac_ctrl_decode
    import dmac_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int ADDR_SHIFT = 0
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [3:0]        offset,
    output ctl_wr_t           wr_dec
);
    assign offset       = addr[ADDR_SHIFT+3 -: 4];
    assign wr_dec.valid = wr_en && !offset[3];
    assign wr_dec.op    = ctl_op_e'(offset[2:0]);
endmodule

// File: rtl/dmac_mode_bank.sv
module dmac_mode_bank
    import dmac_ctrl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  ctl_wr_t             wr_dec,
    input  logic [7:0]          wdata,
    output logic [2*NUM_CH-1:0] mode_xfer,
    output logic [NUM_CH-1:0]   mode_autoinit,
    output logic [NUM_CH-1:0]   mode_decr,
    output logic [2*NUM_CH-1:0] mode_op
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        chan_mode_t mode_r;
        always_ff @(posedge clk) begin
            if (rst)
                mode_r <= '0;
            else if (wr_dec.valid && wr_dec.op == OP_MODE &&
                     wdata[CH_SEL_W-1:0] == CH_SEL_W'(ch))
                mode_r <= chan_mode_t'(wdata[7:2]);
        end
        assign mode_xfer[2*ch +: 2] = mode_r.xfer;
        assign mode_autoinit[ch]    = mode_r.autoinit;
        assign mode_decr[ch]        = mode_r.decr;
        assign mode_op[2*ch +: 2]   = mode_r.op_mode;
    end
endmodule

// File: rtl/dmac_chan_state.sv
module dmac_chan_state
    import dmac_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctl_wr_t           wr_dec,
    input  logic [7:0]        wdata,
    input  logic              status_rd,
    input  logic [NUM_CH-1:0] ext_hold,
    input  logic [NUM_CH-1:0] ext_release,
    input  logic [NUM_CH-1:0] tc_set,
    input  logic              ptr_toggle,
    output logic [7:0]        cmd_q,
    output logic [NUM_CH-1:0] mask_q,
    output logic [NUM_CH-1:0] req_q,
    output logic [NUM_CH-1:0] tc_q,
    output logic              byte_ptr,
    output logic              rescan
);
    logic is_mreset, rescan_d;
    logic [NUM_CH-1:0] mask_d, req_d, tc_d;

    assign is_mreset = wr_dec.valid && wr_dec.op == OP_MRESET;
    assign rescan_d  = (wr_dec.valid && (wr_dec.op == OP_REQ || wr_dec.op == OP_SMASK ||
                        wr_dec.op == OP_CLRMASK || wr_dec.op == OP_WRMASK)) ||
                       (|ext_hold) || (|ext_release);

    always_comb begin
        mask_d = mask_q;
        req_d  = req_q;
        tc_d   = tc_q;
        if (status_rd)
            tc_d = '0;
        if (wr_dec.valid) begin
            case (wr_dec.op)
                OP_REQ: begin
                    req_d[wdata[CH_SEL_W-1:0]] = wdata[2];
                    tc_d[wdata[CH_SEL_W-1:0]]  = 1'b0;
                end
                OP_SMASK:   mask_d[wdata[CH_SEL_W-1:0]] = wdata[2];
                OP_MRESET: begin
                    mask_d = '1;
                    req_d  = '0;
                    tc_d   = '0;
                end
                OP_CLRMASK: mask_d = '0;
                OP_WRMASK:  mask_d = wdata[NUM_CH-1:0];
                default: ;
            endcase
        end
        req_d = (req_d & ~ext_release) | ext_hold;
        tc_d  = tc_d | tc_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= '0;
            mask_q   <= '1;
            req_q    <= '0;
            tc_q     <= '0;
            byte_ptr <= 1'b0;
            rescan   <= 1'b0;
        end else begin
            mask_q <= mask_d;
            req_q  <= req_d;
            tc_q   <= tc_d;
            rescan <= rescan_d;
            if (is_mreset)
                cmd_q <= '0;
            else if (wr_dec.valid && wr_dec.op == OP_CMD && cmd_allowed(wdata))
                cmd_q <= wdata;
            if (is_mreset || (wr_dec.valid && wr_dec.op == OP_CLRPTR))
                byte_ptr <= 1'b0;
            else if (ptr_toggle)
                byte_ptr <= !byte_ptr;
        end
    end
endmodule

// File: rtl/dmac_ctrl_regs.sv
module dmac_ctrl_regs
    import dmac_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int ADDR_SHIFT = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [3:0]        ext_hold,
    input  logic [3:0]        ext_release,
    input  logic [3:0]        tc_set,
    input  logic              ptr_toggle,
    output logic              byte_ptr,
    output logic [7:0]        cmd_q,
    output logic [3:0]        mask_q,
    output logic [7:0]        status_q,
    output logic              rescan,
    output logic [7:0]        mode_xfer,
    output logic [3:0]        mode_autoinit,
    output logic [3:0]        mode_decr,
    output logic [7:0]        mode_op
);
    logic [3:0]        offset;
    ctl_wr_t           wr_dec;
    logic              status_rd;
    logic [NUM_CH-1:0] req_q, tc_q;
    logic [7:0]        rd_mux;

    dmac_ctrl_decode #(.ADDR_W(ADDR_W), .ADDR_SHIFT(ADDR_SHIFT)) u_dec (
        .wr_en(wr_en), .addr(addr), .offset(offset), .wr_dec(wr_dec)
    );

    assign status_rd = rd_en && offset == 4'd0;

    dmac_chan_state u_state (
        .clk(clk), .rst(rst), .wr_dec(wr_dec), .wdata(wdata),
        .status_rd(status_rd), .ext_hold(ext_hold), .ext_release(ext_release),
        .tc_set(tc_set), .ptr_toggle(ptr_toggle), .cmd_q(cmd_q),
        .mask_q(mask_q), .req_q(req_q), .tc_q(tc_q), .byte_ptr(byte_ptr),
        .rescan(rescan)
    );

    dmac_mode_bank u_modes (
        .clk(clk), .rst(rst), .wr_dec(wr_dec), .wdata(wdata),
        .mode_xfer(mode_xfer), .mode_autoinit(mode_autoinit),
        .mode_decr(mode_decr), .mode_op(mode_op)
    );

    assign status_q = {req_q, tc_q};

    always_comb begin
        case (offset)
            4'd0:    rd_mux = status_q;
            4'd1:    rd_mux = {4'b0000, mask_q};
            default: rd_mux = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= 8'h00;
        else if (rd_en)
            rdata <= rd_mux;
    end
endmodule

// File: rtl/dmac_ctrl_chk.sv
module dmac_ctrl_chk #(
    parameter int ADDR_W     = 5,
    parameter int ADDR_SHIFT = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic [3:0]        ext_hold,
    input logic [3:0]        ext_release,
    input logic [3:0]        tc_set,
    input logic [7:0]        cmd_q,
    input logic [3:0]        mask_q,
    input logic [7:0]        status_q,
    input logic              rescan
);
    logic [3:0] off;
    logic       trig;
    assign off  = addr[ADDR_SHIFT+3 -: 4];
    assign trig = (wr_en && (off == 4'd1 || off == 4'd2 || off == 4'd6 || off == 4'd7)) ||
                  (|ext_hold) || (|ext_release);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (mask_q == 4'hF && status_q == 8'h00 && cmd_q == 8'h00));

    // R2
    cmd_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && off == 4'd0 && (wdata & 8'hFB) != 8'h00) |=> $stable(cmd_q));

    // R9
    status_rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && off == 4'd0 && tc_set == 4'h0) |=> status_q[3:0] == 4'h0);

    // R11
    rescan_cause_chk: assert property (@(posedge clk) disable iff (rst)
        rescan |-> $past(trig));

    // R11
    rescan_fire_chk: assert property (@(posedge clk) disable iff (rst)
        trig |=> rescan);

    // R13
    ext_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (|ext_hold) |=> (status_q[7:4] & $past(ext_hold)) == $past(ext_hold));

    // R14
    tc_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|tc_set) |=> (status_q[3:0] & $past(tc_set)) == $past(tc_set));
endmodule

bind dmac_ctrl_regs dmac_ctrl_chk #(.ADDR_W(ADDR_W), .ADDR_SHIFT(ADDR_SHIFT)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .ext_hold(ext_hold), .ext_release(ext_release),
    .tc_set(tc_set), .cmd_q(cmd_q), .mask_q(mask_q), .status_q(status_q),
    .rescan(rescan)
);

// File: tb/dmac_ctrl_regs_tb.sv
module dmac_ctrl_regs_tb;
    logic clk = 1'b0;
    always #2.5 clk = !clk;

    logic       rst, wr_en, rd_en, ptr_toggle;
    logic [4:0] addr;
    logic [7:0] wdata;
    logic [3:0] ext_hold, ext_release, tc_set;
    logic [7:0] rdata, cmd_q, status_q, mode_xfer, mode_op;
    logic [3:0] mask_q, mode_autoinit, mode_decr;
    logic       byte_ptr, rescan;

    logic       w_wr;
    logic [4:0] w_addr;
    logic [7:0] w_wdata, w_rdata, w_cmd, w_status, w_mx, w_mo;
    logic [3:0] w_mask, w_ma, w_md;
    logic       w_bp, w_rescan;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    dmac_ctrl_regs #(.ADDR_W(5), .ADDR_SHIFT(0)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ext_hold(ext_hold), .ext_release(ext_release),
        .tc_set(tc_set), .ptr_toggle(ptr_toggle), .byte_ptr(byte_ptr), .cmd_q(cmd_q),
        .mask_q(mask_q), .status_q(status_q), .rescan(rescan), .mode_xfer(mode_xfer),
        .mode_autoinit(mode_autoinit), .mode_decr(mode_decr), .mode_op(mode_op)
    );

    dmac_ctrl_regs #(.ADDR_W(5), .ADDR_SHIFT(1)) u_dut_w (
        .clk(clk), .rst(rst), .wr_en(w_wr), .rd_en(1'b0), .addr(w_addr),
        .wdata(w_wdata), .rdata(w_rdata), .ext_hold(4'h0), .ext_release(4'h0),
        .tc_set(4'h0), .ptr_toggle(1'b0), .byte_ptr(w_bp), .cmd_q(w_cmd),
        .mask_q(w_mask), .status_q(w_status), .rescan(w_rescan), .mode_xfer(w_mx),
        .mode_autoinit(w_ma), .mode_decr(w_md), .mode_op(w_mo)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic rd, input logic [4:0] a,
                        input logic [7:0] d, input logic [3:0] hold,
                        input logic [3:0] rel, input logic [3:0] tc, input logic tog);
        @(negedge clk);
        wr_en = wr; rd_en = rd; addr = a; wdata = d;
        ext_hold = hold; ext_release = rel; tc_set = tc; ptr_toggle = tog;
        @(negedge clk);
        wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
        ext_hold = 0; ext_release = 0; tc_set = 0; ptr_toggle = 0;
    endtask

    task automatic wstep(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        w_wr = 1; w_addr = a; w_wdata = d;
        @(negedge clk);
        w_wr = 0; w_addr = 0; w_wdata = 0;
    endtask

    // {offset[3:0], data[7:0], exp_mask[3:0], exp_status[7:0], exp_cmd[7:0]}
    localparam int NV = 11;
    localparam logic [31:0] VEC [NV] = '{
        {4'd0, 8'h04, 4'hF, 8'h00, 8'h04},   // R2 accepted
        {4'd0, 8'h10, 4'hF, 8'h00, 8'h04},   // R2 rejected
        {4'd2, 8'h00, 4'hE, 8'h00, 8'h04},   // R4 clear ch0
        {4'd2, 8'h02, 4'hA, 8'h00, 8'h04},   // R4 clear ch2
        {4'd1, 8'h05, 4'hA, 8'h20, 8'h04},   // R3 set req ch1
        {4'd7, 8'h09, 4'h9, 8'h20, 8'h04},   // R8 load mask
        {4'd6, 8'h00, 4'h0, 8'h20, 8'h04},   // R8 clear all
        {4'd2, 8'h07, 4'h8, 8'h20, 8'h04},   // R4 set ch3
        {4'd1, 8'h01, 4'h8, 8'h00, 8'h04},   // R3 clear req ch1
        {4'd8, 8'hFF, 4'h8, 8'h00, 8'h04},   // R12 offset 8 ignored
        {4'd5, 8'h00, 4'hF, 8'h00, 8'h00}    // R7 master reset
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
        ext_hold = 0; ext_release = 0; tc_set = 0; ptr_toggle = 0;
        w_wr = 0; w_addr = 0; w_wdata = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 mask", 32'(mask_q), 32'hF);
        check("R1 status", 32'(status_q), 32'h0);
        check("R1 cmd", 32'(cmd_q), 32'h0);
        check("R1 modes", {mode_xfer, mode_op, mode_autoinit, mode_decr, 8'h00}, 32'h0);
        check("R1 ptr/rdata", {23'h0, byte_ptr, rdata}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            step(1'b1, 1'b0, {1'b0, VEC[i][31:28]}, VEC[i][27:20], 4'h0, 4'h0, 4'h0, 1'b0);
            check("R2/R3/R4/R7/R8/R12 vec", {12'h0, mask_q, status_q, cmd_q}, {12'h0, VEC[i][19:0]});
        end

        // R5 mode write to ch2
        step(1, 0, 5'd3, 8'hB6, 0, 0, 0, 0);
        check("R5 fields", {mode_xfer, mode_op, mode_autoinit, mode_decr, 8'h00},
              {8'h10, 8'h20, 4'h4, 4'h4, 8'h00});
        check("R11 no rescan on mode", 32'(rescan), 32'h0);

        // R6 byte pointer
        step(0, 0, 0, 0, 0, 0, 0, 1);
        check("R6 toggle", 32'(byte_ptr), 32'h1);
        step(1, 0, 5'd4, 8'h00, 0, 0, 0, 0);
        check("R6 clear", 32'(byte_ptr), 32'h0);
        step(0, 0, 0, 0, 0, 0, 0, 1);
        step(1, 0, 5'd5, 8'h00, 0, 0, 0, 0);
        check("R7 clears ptr", 32'(byte_ptr), 32'h0);

        // R9 status read, R13 hold, R14 tc
        step(0, 0, 0, 0, 4'h8, 0, 4'h3, 0);
        check("R13 R14 status", 32'(status_q), 32'h83);
        check("R11 rescan on hold", 32'(rescan), 32'h1);
        step(0, 1, 5'd0, 0, 0, 0, 0, 0);
        check("R9 rdata", 32'(rdata), 32'h83);
        check("R9 cleared", 32'(status_q), 32'h80);
        step(0, 1, 5'd0, 0, 0, 0, 0, 0);
        check("R9 second read", 32'(rdata), 32'h80);

        // R10 reads
        step(1, 0, 5'd7, 8'h05, 0, 0, 0, 0);
        check("R11 rescan on wrmask", 32'(rescan), 32'h1);
        step(0, 1, 5'd1, 0, 0, 0, 0, 0);
        check("R10 mask read", 32'(rdata), 32'h05);
        check("R11 no rescan idle", 32'(rescan), 32'h0);
        step(0, 1, 5'd3, 0, 0, 0, 0, 0);
        check("R10 other read", 32'(rdata), 32'h00);

        // R3 clears terminal count
        step(0, 0, 0, 0, 0, 0, 4'h4, 0);
        step(1, 0, 5'd1, 8'h02, 0, 0, 0, 0);
        check("R3 tc clear", 32'(status_q), 32'h80);

        // R13 priority
        step(1, 0, 5'd1, 8'h04, 0, 4'h1, 0, 0);
        check("R13 release wins", 32'(status_q[4]), 32'h0);
        step(1, 0, 5'd1, 8'h01, 4'h2, 0, 0, 0);
        check("R13 hold wins", 32'(status_q[5]), 32'h1);
        step(0, 0, 0, 0, 4'h1, 4'h1, 0, 0);
        check("R13 hold over release", 32'(status_q[4]), 32'h1);

        // R14 priority over clear
        step(1, 0, 5'd1, 8'h00, 0, 0, 4'h1, 0);
        check("R14 tc wins", 32'(status_q[0]), 32'h1);

        // R12 word-spaced decoding
        wstep(5'h05, 8'h00);
        check("R12 shift offset 2", 32'(w_mask), 32'hE);
        wstep(5'h10, 8'h00);
        check("R12 shift offset 8", 32'(w_mask), 32'hE);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule